// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs beside a serial audio port that works as a clock slave. The frame clock and the bit clock arrive from outside, and the frame clock is derived synchronously from the master clock at the sample rate. Nominally the bit clock runs at 64 times the frame rate, though other bit rates can occur. The block does not use the bit clock. It counts master-clock cycles from one rising frame edge to the next. It then works out whether the master clock runs at 256, 384 or 512 times the frame rate.

Each measured period is compared against the three nominal counts with a tolerance of two cycles. Lock is declared once two back-to-back periods fall into the same class. The block then freezes the ratio code and the divider terminal counts that the internal clock generators need. These stay fixed until the next reset, so later drift or glitches on the frame input cannot disturb a running converter. A period that fits no class raises an error flag, and the block stays in acquisition.

Top module: `mrd_top`

## Requirements
- R1: While reset is held and right after it is released, `locked_o` and `error_o` are 0, `ratio_o` is 2'b11 (no ratio) and both terminal-count outputs are 0.
- R2: A measured period of 254..258 cycles maps to code 2'b00 (256x), 382..386 maps to 2'b01 (384x) and 510..514 maps to 2'b10 (512x).
- R3: The first rising frame edge after reset only starts the measurement. Lock is declared after two consecutive measured periods fall into the same class, even when their exact counts differ.
- R4: A measured period outside every window sets `error_o` and keeps the block unlocked. The next in-window period clears `error_o`.
- R5: Periods whose classes alternate never produce lock.
- R6: Once locked, `locked_o`, `ratio_o` and the terminal counts stay frozen and `error_o` stays 0 until reset, whatever the frame input does.
- R7: When locked with nominal ratio N, `frame_tc_o` equals N-1 and `bit_tc_o` equals N/64-1 (255/3, 383/5, 511/7). Both are 0 while unlocked.
- R8: The frame input passes through a two-stage synchronizer, and periods are measured between rising edges. A frame input that never toggles produces neither lock nor error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | External frame clock, asynchronous to the detector |
| ratio_o | output | 2 | Detected ratio: 00=256, 01=384, 10=512, 11=none |
| locked_o | output | 1 | Ratio detected and frozen |
| error_o | output | 1 | Last measured period matched no ratio |
| frame_tc_o | output | 11 | Frame divider terminal count (ratio-1) |
| bit_tc_o | output | 3 | Bit-clock divider terminal count (ratio/64-1) |

## Verification
The classifier is driven with steady frame periods at each nominal count, at both tolerance edges, and one cycle beyond each edge. These show that every window has exactly the intended width and code. Patterns with mixed periods separate correct lock behaviour from faulty ones:
- jittered but same-class periods must lock;
- alternating classes must not lock;
- an out-of-window period followed by good ones must first raise the error flag and then clear it.

A change of frame period after lock and a frame input that never toggles check that the frozen state is kept and that no edge means no decision.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [1:0] {
    RATIO_256  = 2'b00,
    RATIO_384  = 2'b01,
    RATIO_512  = 2'b10,
    RATIO_NONE = 2'b11
  } ratio_e;

  localparam int unsigned NUM_RATIOS = 3;

  typedef enum logic {
    ST_ACQUIRE = 1'b0,
    ST_LOCKED  = 1'b1
  } lock_state_e;

endpackage

// File: rtl/mrd_sync.sv
module mrd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
    end else begin
      sh_q <= {sh_q[STAGES-1:0], async_i};
    end
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  // A rising edge needs a low sample before it, so two rises never abut
  assert_rise_isolated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] count_o
);

  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
      count_q <= '0;
    end else if (rise_i) begin
      valid_q <= armed_q;
      if (armed_q) begin
        count_q <= cnt_q;
      end
      cnt_q   <= CNT_W'(1);
      armed_q <= 1'b1;
    end else begin
      valid_q <= 1'b0;
      if (cnt_q != '1) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign valid_o = valid_q;
  assign count_o = count_q;

  // A finished period always spans at least two master-clock cycles
  assert_period_nonzero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (count_o > CNT_W'(1)));

  assert_valid_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
  import mrd_pkg::*;
#(
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned BASE_RATIO = 256,
  parameter int unsigned STEP_RATIO = 128,
  parameter int unsigned TOL        = 2
) (
  input  logic [CNT_W-1:0] count_i,
  output logic             match_o,
  output ratio_e           code_o
);

  logic [NUM_RATIOS-1:0] hit;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
    localparam int unsigned NOM = BASE_RATIO + STEP_RATIO * g;
    localparam logic [CNT_W-1:0] LO = CNT_W'(NOM - TOL);
    localparam logic [CNT_W-1:0] HI = CNT_W'(NOM + TOL);
    assign hit[g] = (count_i >= LO) && (count_i <= HI);
  end

  always_comb begin
    match_o = |hit;
    code_o  = RATIO_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        code_o = ratio_e'(2'(i));
      end
    end
    assert_windows_disjoint_R2: assert ($onehot0(hit));
  end

endmodule

// File: rtl/mrd_lock_fsm.sv
module mrd_lock_fsm
  import mrd_pkg::*;
#(
  parameter int unsigned CNT_W      = 11,
  parameter int unsigned BTC_W      = 3,
  parameter int unsigned BASE_RATIO = 256,
  parameter int unsigned STEP_RATIO = 128,
  parameter int unsigned BIT_RATIO  = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             match_i,
  input  ratio_e           code_i,
  output logic             locked_o,
  output logic             error_o,
  output ratio_e           ratio_o,
  output logic [CNT_W-1:0] frame_tc_o,
  output logic [BTC_W-1:0] bit_tc_o
);

  lock_state_e      state_q;
  logic             prev_ok_q;
  ratio_e           prev_code_q;
  logic             error_q;
  ratio_e           ratio_q;
  logic [CNT_W-1:0] frame_tc_q;
  logic [BTC_W-1:0] bit_tc_q;

  int unsigned      nom;
  logic             same_twice;

  always_comb begin
    nom        = BASE_RATIO + STEP_RATIO * int'(code_i);
    same_twice = prev_ok_q && (prev_code_q == code_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_ACQUIRE;
      prev_ok_q   <= 1'b0;
      prev_code_q <= RATIO_NONE;
      error_q     <= 1'b0;
      ratio_q     <= RATIO_NONE;
      frame_tc_q  <= '0;
      bit_tc_q    <= '0;
    end else if (state_q == ST_ACQUIRE && valid_i) begin
      if (!match_i) begin
        error_q   <= 1'b1;
        prev_ok_q <= 1'b0;
      end else begin
        error_q     <= 1'b0;
        prev_ok_q   <= 1'b1;
        prev_code_q <= code_i;
        if (same_twice) begin
          state_q    <= ST_LOCKED;
          ratio_q    <= code_i;
          frame_tc_q <= CNT_W'(nom - 1);
          bit_tc_q   <= BTC_W'(nom / BIT_RATIO - 1);
        end
      end
    end
  end

  assign locked_o   = (state_q == ST_LOCKED);
  assign error_o    = error_q;
  assign ratio_o    = ratio_q;
  assign frame_tc_o = frame_tc_q;
  assign bit_tc_o   = bit_tc_q;

  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);

  assert_ratio_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> ($stable(ratio_o) && $stable(frame_tc_o) && $stable(bit_tc_o)));

  assert_no_error_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> !error_o);

  assert_lock_on_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(valid_i && match_i));

  assert_locked_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (ratio_o != RATIO_NONE));

  assert_tc_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> (frame_tc_o == '0 && bit_tc_o == '0));

endmodule

// File: rtl/mrd_top.sv
module mrd_top
  import mrd_pkg::*;
#(
  parameter int unsigned BASE_RATIO  = 256,
  parameter int unsigned STEP_RATIO  = 128,
  parameter int unsigned TOL         = 2,
  parameter int unsigned BIT_RATIO   = 64,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MAX_NOM    = BASE_RATIO + STEP_RATIO * (NUM_RATIOS - 1),
  localparam int unsigned CNT_W      = $clog2(MAX_NOM + TOL + 1) + 1,
  localparam int unsigned BTC_W      = $clog2(MAX_NOM / BIT_RATIO)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  output logic [1:0]       ratio_o,
  output logic             locked_o,
  output logic             error_o,
  output logic [CNT_W-1:0] frame_tc_o,
  output logic [BTC_W-1:0] bit_tc_o
);

  logic             rise;
  logic             period_valid;
  logic [CNT_W-1:0] period_count;
  logic             win_match;
  ratio_e           win_code;
  ratio_e           ratio_q;

  mrd_sync #(
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (frame_i),
    .rise_o  (rise)
  );

  mrd_period_counter #(
    .CNT_W (CNT_W)
  ) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rise_i  (rise),
    .valid_o (period_valid),
    .count_o (period_count)
  );

  mrd_classifier #(
    .CNT_W      (CNT_W),
    .BASE_RATIO (BASE_RATIO),
    .STEP_RATIO (STEP_RATIO),
    .TOL        (TOL)
  ) i_classifier (
    .count_i (period_count),
    .match_o (win_match),
    .code_o  (win_code)
  );

  mrd_lock_fsm #(
    .CNT_W      (CNT_W),
    .BTC_W      (BTC_W),
    .BASE_RATIO (BASE_RATIO),
    .STEP_RATIO (STEP_RATIO),
    .BIT_RATIO  (BIT_RATIO)
  ) i_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (period_valid),
    .match_i    (win_match),
    .code_i     (win_code),
    .locked_o   (locked_o),
    .error_o    (error_o),
    .ratio_o    (ratio_q),
    .frame_tc_o (frame_tc_o),
    .bit_tc_o   (bit_tc_o)
  );

  assign ratio_o = ratio_q;

endmodule

// File: tb/test_mrd_top.sv
module test_mrd_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  localparam int       VEC_P    [NVEC] = '{256, 254, 258, 253, 259, 384, 382, 386,
                                           381, 512, 514, 510, 515, 448, 100};
  localparam bit       VEC_LOCK [NVEC] = '{1, 1, 1, 0, 0, 1, 1, 1, 0, 1, 1, 1, 0, 0, 0};
  localparam bit [1:0] VEC_CODE [NVEC] = '{2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b01, 2'b01,
                                           2'b01, 2'b11, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11,
                                           2'b11};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame = 1'b0;
  logic [1:0]  ratio;
  logic        locked;
  logic        error;
  logic [10:0] frame_tc;
  logic [2:0]  bit_tc;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mrd_top i_mrd_top (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .frame_i    (frame),
    .ratio_o    (ratio),
    .locked_o   (locked),
    .error_o    (error),
    .frame_tc_o (frame_tc),
    .bit_tc_o   (bit_tc)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Full state check; code 3 means unlocked, so the terminal counts must read 0
  task automatic check_state(input string req, input bit lk, input bit [1:0] code, input bit er);
    int nom;
    check(req, "locked", int'(locked), int'(lk));
    check(req, "ratio", int'(ratio), int'(code));
    check(req, "error", int'(error), int'(er));
    nom = (code == 2'b11) ? 0 : 256 + 128 * int'(code);
    check("R7", "frame_tc", int'(frame_tc), (nom == 0) ? 0 : nom - 1);
    check("R7", "bit_tc", int'(bit_tc), (nom == 0) ? 0 : nom / 64 - 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // One frame period: high for half, low for the rest
  task automatic run_period(input int p);
    frame = 1'b1;
    repeat (p / 2) @(negedge clk);
    frame = 1'b0;
    repeat (p - p / 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (2) @(negedge clk);
    check_state("R1", 1'b0, 2'b11, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_state("R1", 1'b0, 2'b11, 1'b0);

    // R2 / R4: steady-period table, four periods give three measurements
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      for (int k = 0; k < 4; k++) run_period(VEC_P[v]);
      repeat (8) @(negedge clk);
      check_state(VEC_LOCK[v] ? "R2" : "R4", VEC_LOCK[v], VEC_CODE[v], !VEC_LOCK[v]);
    end

    // R3: first edge only arms; jittered same-class periods lock on the second measurement
    do_reset();
    run_period(255);
    check_state("R3", 1'b0, 2'b11, 1'b0);
    run_period(257);
    check_state("R3", 1'b0, 2'b11, 1'b0);
    run_period(300);
    check_state("R3", 1'b1, 2'b00, 1'b0);

    // R6: period change and bad periods after lock leave everything frozen
    for (int k = 0; k < 3; k++) run_period(384);
    for (int k = 0; k < 3; k++) run_period(100);
    repeat (8) @(negedge clk);
    check_state("R6", 1'b1, 2'b00, 1'b0);

    // R5: alternating classes never lock
    do_reset();
    for (int k = 0; k < 6; k++) run_period((k % 2 == 0) ? 256 : 384);
    repeat (8) @(negedge clk);
    check_state("R5", 1'b0, 2'b11, 1'b0);

    // R4: error on a bad period, cleared by the next good one, then lock
    do_reset();
    run_period(300);
    run_period(300);
    check_state("R4", 1'b0, 2'b11, 1'b1);
    run_period(512);
    run_period(512);
    check_state("R4", 1'b0, 2'b11, 1'b0);
    run_period(512);
    check_state("R4", 1'b1, 2'b10, 1'b0);

    // R8: a frame input that never toggles gives no decision
    do_reset();
    repeat (3000) @(negedge clk);
    check_state("R8", 1'b0, 2'b11, 1'b0);

    // R1: reset after lock returns to the idle state
    do_reset();
    for (int k = 0; k < 3; k++) run_period(384);
    check_state("R3", 1'b1, 2'b01, 1'b0);
    do_reset();
    check_state("R1", 1'b0, 2'b11, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule